// File: doc/BRIEF.md
# Raster Timing Generator with Burst Pixel Fetch

This block drives a parallel flat panel. Two counters produce the raster. One counter steps across the pixels of a line, and the other steps down the lines of a frame. From these counters the block derives the sync pulses and the data-enable window. Pixel words come from frame memory, which the block reads in fixed-length bursts on the bus clock through a request/acknowledge port. The words pass through a dual-clock FIFO to the pixel-clock side. That side pops one word for each active pixel. The FIFO refills while the raster is in horizontal or vertical blanking.

Software writes a small register bank over a write-only configuration bus. The bank holds the four segment lengths of each axis, the frame base address and a control word. The control word enables the block, selects between separate syncs and a single data-enable, sets each sync polarity and selects 18- or 24-bit colour. Timing fields, base address and mode bits are treated as static while the raster is running. Only the enable bit is synchronised into the pixel domain.

Top module: `dtp_display_ctrl`

## Requirements
- R1: While either reset is asserted and after release with no writes: mem_req is 0, pix_de is 0, pix_rgb is 0, pix_underflow is 0, and both syncs sit at their inactive level, which is high.
- R2: A write with cfg_wr high stores cfg_wdata at word address cfg_addr. Address 0 is control, with bit 0 enable, bit 1 data-enable mode, bit 2 hsync active-high, bit 3 vsync active-high and bit 4 18-bit colour. Addresses 1 to 4 hold the horizontal active, front porch, sync and back porch lengths, and addresses 5 to 8 hold the vertical lengths in the same order. Address 9 holds the frame base word address.
- R3: A line lasts active+front+sync+back pixel clocks. The line counter advances only when the pixel counter wraps. Hsync is asserted for the horizontal sync length, starting active+front clocks into the line. Vsync is asserted for the vertical sync length in whole lines.
- R4: A set polarity bit makes that sync active-high. A clear polarity bit makes it active-low.
- R5: In data-enable mode, pix_de is high exactly while both counters are in their active region, so each line has the horizontal active length of pixels and each frame has the vertical active count of lines, and both syncs are held inactive. In sync mode, pix_de stays low.
- R6: Active pixels show, in raster order, the memory words at base + y*active_width + x. pix_rgb is zero outside the active region.
- R7: Memory is read in bursts of BURST words at base, base+BURST and onward. The address returns to base after active_width*active_lines words, a count that must be a multiple of BURST. mem_req with its address holds until mem_ack, and a burst is requested only when the FIFO has room for all of it.
- R8: On enable the raster starts at the first line of vertical front porch. The first pix_de therefore appears (vfront+vsync+vback)*line_length pixel clocks after enable, plus a few clocks of synchroniser and output latency.
- R9: With 18-bit colour selected, the two low bits of each 8-bit channel of pix_rgb are zero.
- R10: An active pixel that finds the FIFO empty is shown as the fixed colour UF_COLOR and sets pix_underflow. pix_underflow stays set until pixel reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus and memory clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 24 | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 24 | Burst start word address |
| mem_ack | input | 1 | Burst request accepted |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 24 | Read data beat |
| clk_pix | input | 1 | Pixel clock |
| rst_pix_n | input | 1 | Active-low reset, pixel domain |
| pix_rgb | output | 24 | Pixel colour, 8 bits per channel |
| pix_hsync | output | 1 | Horizontal sync |
| pix_vsync | output | 1 | Vertical sync |
| pix_de | output | 1 | Data enable |
| pix_underflow | output | 1 | Sticky FIFO starvation flag |

## Verification
If a fetch pointer or FIFO pointer goes wrong, the next active pixel shows a memory word at the wrong offset. That error repeats on every later pixel, so a single frame of data comparison exposes it. If a raster counter wraps at the wrong point, the pulse widths and periods of the syncs and data-enable change within one line, or within one frame for the vertical counter. Starvation shows up in the first starved pixel as the fixed colour, together with the sticky flag one clock later.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int TW = 12;
  localparam int AW = 24;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_HACT  = 4'd1;
  localparam logic [3:0] REG_HFP   = 4'd2;
  localparam logic [3:0] REG_HSYN  = 4'd3;
  localparam logic [3:0] REG_HBP   = 4'd4;
  localparam logic [3:0] REG_VACT  = 4'd5;
  localparam logic [3:0] REG_VFP   = 4'd6;
  localparam logic [3:0] REG_VSYN  = 4'd7;
  localparam logic [3:0] REG_VBP   = 4'd8;
  localparam logic [3:0] REG_BASE  = 4'd9;

  typedef struct packed {
    logic          en;
    logic          de_mode;
    logic          hpol;
    logic          vpol;
    logic          mode18;
    logic [TW-1:0] h_act;
    logic [TW-1:0] h_fp;
    logic [TW-1:0] h_sync;
    logic [TW-1:0] h_bp;
    logic [TW-1:0] v_act;
    logic [TW-1:0] v_fp;
    logic [TW-1:0] v_sync;
    logic [TW-1:0] v_bp;
    logic [AW-1:0] base;
  } dtp_cfg_t;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_st_e;
endpackage

// File: rtl/dtp_regs.sv
module dtp_regs
  import dtp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [AW-1:0] wdata,
  output dtp_cfg_t      cfg
);
  dtp_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      case (addr)
        REG_CTRL: begin
          cfg_d.en      = wdata[0];
          cfg_d.de_mode = wdata[1];
          cfg_d.hpol    = wdata[2];
          cfg_d.vpol    = wdata[3];
          cfg_d.mode18  = wdata[4];
        end
        REG_HACT: cfg_d.h_act  = wdata[TW-1:0];
        REG_HFP:  cfg_d.h_fp   = wdata[TW-1:0];
        REG_HSYN: cfg_d.h_sync = wdata[TW-1:0];
        REG_HBP:  cfg_d.h_bp   = wdata[TW-1:0];
        REG_VACT: cfg_d.v_act  = wdata[TW-1:0];
        REG_VFP:  cfg_d.v_fp   = wdata[TW-1:0];
        REG_VSYN: cfg_d.v_sync = wdata[TW-1:0];
        REG_VBP:  cfg_d.v_bp   = wdata[TW-1:0];
        REG_BASE: cfg_d.base   = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dtp_afifo.sv
module dtp_afifo #(
  parameter int W      = 24,
  parameter int DEPTH  = 16,
  parameter int SYNC_N = 2
) (
  input  logic                       wclk,
  input  logic                       wrst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  output logic [$clog2(DEPTH):0]     wr_free,
  input  logic                       rclk,
  input  logic                       rrst_n,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       rd_empty
);
  localparam int PA = $clog2(DEPTH);
  localparam int PW = PA + 1;

  logic [W-1:0]               mem [DEPTH];
  logic [PW-1:0]              wbin_q, wbin_d, wgray_q;
  logic [PW-1:0]              rbin_q, rbin_d, rgray_q;
  logic [SYNC_N-1:0][PW-1:0]  r2w, w2r;
  logic [PW-1:0]              rbin_at_w;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  always_comb wbin_d = wbin_q + PW'(wr_en);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      r2w     <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      r2w     <= {r2w[SYNC_N-2:0], rgray_q};
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wbin_q[PA-1:0]] <= wr_data;
  end

  always_comb begin
    rbin_at_w = g2b(r2w[SYNC_N-1]);
    wr_free   = PW'(DEPTH) - (wbin_q - rbin_at_w);
  end

  // read side
  always_comb rbin_d = rbin_q + PW'(rd_en);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      w2r     <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      w2r     <= {w2r[SYNC_N-2:0], wgray_q};
    end
  end

  assign rd_empty = (rgray_q == w2r[SYNC_N-1]);
  assign rd_data  = mem[rbin_q[PA-1:0]];

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_en |-> (wr_free != '0)); // R7
  AST_FREE_BOUND: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_free <= PW'(DEPTH)); // R7
endmodule

// File: rtl/dtp_fetch.sv
module dtp_fetch
  import dtp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BURST  = 4,
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [AW-1:0]     base,
  input  logic [TW-1:0]     h_act,
  input  logic [TW-1:0]     v_act,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata
);
  localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int FW  = 2 * TW;

  fetch_st_e      st_q, st_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [FW-1:0]  left_q, left_d;
  logic [BCW-1:0] beat_q, beat_d;
  logic [FW-1:0]  frame_words;

  assign frame_words = h_act * v_act;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    beat_d = beat_q;
    case (st_q)
      F_IDLE: begin
        if (!en) begin
          addr_d = base;
          left_d = frame_words;
        end else if (fifo_free >= FREE_W'(BURST)) begin
          st_d = F_REQ;
        end
      end
      F_REQ: begin
        if (mem_ack) begin
          st_d   = F_DATA;
          beat_d = '0;
        end
      end
      F_DATA: begin
        if (mem_rvalid) begin
          if (beat_q == BCW'(BURST - 1)) begin
            st_d = F_IDLE;
            if (left_q <= FW'(BURST)) begin
              addr_d = base;
              left_d = frame_words;
            end else begin
              addr_d = addr_q + AW'(BURST);
              left_d = left_q - FW'(BURST);
            end
          end else begin
            beat_d = beat_q + BCW'(1);
          end
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
      left_q <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      beat_q <= beat_d;
    end
  end

  assign mem_req    = (st_q == F_REQ);
  assign mem_addr   = addr_q;
  assign fifo_we    = (st_q == F_DATA) && mem_rvalid;
  assign fifo_wdata = mem_rdata;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R7
endmodule

// File: rtl/dtp_raster.sv
module dtp_raster
  import dtp_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  logic [TW-1:0] h_act,
  input  logic [TW-1:0] h_fp,
  input  logic [TW-1:0] h_sync,
  input  logic [TW-1:0] h_bp,
  input  logic [TW-1:0] v_act,
  input  logic [TW-1:0] v_fp,
  input  logic [TW-1:0] v_sync,
  input  logic [TW-1:0] v_bp,
  output logic          active,
  output logic          hs_in,
  output logic          vs_in
);
  logic [SYNC_N-1:0] en_s;
  logic              run;
  logic [TW-1:0]     h_q, h_d, v_q, v_d;
  logic [TW-1:0]     h_last, v_last, hs_lo, hs_hi, vs_lo, vs_hi;

  assign run    = en_s[SYNC_N-1];
  assign hs_lo  = h_act + h_fp;
  assign hs_hi  = hs_lo + h_sync;
  assign h_last = hs_hi + h_bp - TW'(1);
  assign vs_lo  = v_act + v_fp;
  assign vs_hi  = vs_lo + v_sync;
  assign v_last = vs_hi + v_bp - TW'(1);

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (!run) begin
      h_d = '0;
      v_d = v_act;
    end else if (h_q == h_last) begin
      h_d = '0;
      v_d = (v_q == v_last) ? '0 : v_q + TW'(1);
    end else begin
      h_d = h_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s <= '0;
      h_q  <= '0;
      v_q  <= '0;
    end else begin
      en_s <= {en_s[SYNC_N-2:0], en_async};
      h_q  <= h_d;
      v_q  <= v_d;
    end
  end

  assign active = run && (h_q < h_act) && (v_q < v_act);
  assign hs_in  = run && (h_q >= hs_lo) && (h_q < hs_hi);
  assign vs_in  = run && (v_q >= vs_lo) && (v_q < vs_hi);

  AST_V_STEP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (v_q != $past(v_q))) |-> (h_q == '0)); // R3
  AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (h_q <= h_last)); // R3
endmodule

// File: rtl/dtp_display_ctrl.sv
module dtp_display_ctrl
  import dtp_pkg::*;
#(
  parameter int          DATA_W     = 24,
  parameter int          BURST      = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter int          SYNC_N     = 2,
  parameter logic [23:0] UF_COLOR   = 24'h00FF00
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              clk_pix,
  input  logic              rst_pix_n,
  output logic [DATA_W-1:0] pix_rgb,
  output logic              pix_hsync,
  output logic              pix_vsync,
  output logic              pix_de,
  output logic              pix_underflow
);
  localparam int FREE_W = $clog2(FIFO_DEPTH) + 1;
  localparam int CH_W   = DATA_W / 3;

  dtp_cfg_t           cfg;
  logic [FREE_W-1:0]  fifo_free;
  logic               fifo_we, fifo_empty, fifo_re;
  logic [DATA_W-1:0]  fifo_wdata, fifo_rdata;
  logic               active, hs_in, vs_in;
  logic [DATA_W-1:0]  chan_mask;
  logic [DATA_W-1:0]  rgb_d;
  logic               hs_d, vs_d, de_d, uf_d;

  dtp_regs u_regs (
    .clk(clk_bus), .rst_n(rst_bus_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  dtp_fetch #(.DATA_W(DATA_W), .BURST(BURST), .FREE_W(FREE_W)) u_fetch (
    .clk(clk_bus), .rst_n(rst_bus_n), .en(cfg.en), .base(cfg.base),
    .h_act(cfg.h_act), .v_act(cfg.v_act), .fifo_free(fifo_free),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
  );

  dtp_afifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .SYNC_N(SYNC_N)) u_fifo (
    .wclk(clk_bus), .wrst_n(rst_bus_n), .wr_en(fifo_we), .wr_data(fifo_wdata),
    .wr_free(fifo_free),
    .rclk(clk_pix), .rrst_n(rst_pix_n), .rd_en(fifo_re), .rd_data(fifo_rdata),
    .rd_empty(fifo_empty)
  );

  dtp_raster #(.SYNC_N(SYNC_N)) u_raster (
    .clk(clk_pix), .rst_n(rst_pix_n), .en_async(cfg.en),
    .h_act(cfg.h_act), .h_fp(cfg.h_fp), .h_sync(cfg.h_sync), .h_bp(cfg.h_bp),
    .v_act(cfg.v_act), .v_fp(cfg.v_fp), .v_sync(cfg.v_sync), .v_bp(cfg.v_bp),
    .active(active), .hs_in(hs_in), .vs_in(vs_in)
  );

  // per-channel colour depth mask
  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign chan_mask[c*CH_W +: CH_W] =
      cfg.mode18 ? {{(CH_W-2){1'b1}}, 2'b00} : {CH_W{1'b1}};
  end

  assign fifo_re = active && !fifo_empty;

  always_comb begin
    rgb_d = '0;
    if (active) rgb_d = (fifo_empty ? DATA_W'(UF_COLOR) : fifo_rdata) & chan_mask;
    de_d = active && cfg.de_mode;
    hs_d = (!cfg.de_mode && hs_in) ? cfg.hpol : !cfg.hpol;
    vs_d = (!cfg.de_mode && vs_in) ? cfg.vpol : !cfg.vpol;
    uf_d = pix_underflow || (active && fifo_empty);
  end

  always_ff @(posedge clk_pix or negedge rst_pix_n) begin
    if (!rst_pix_n) begin
      pix_rgb       <= '0;
      pix_de        <= 1'b0;
      pix_hsync     <= 1'b1;
      pix_vsync     <= 1'b1;
      pix_underflow <= 1'b0;
    end else begin
      pix_rgb       <= rgb_d;
      pix_de        <= de_d;
      pix_hsync     <= hs_d;
      pix_vsync     <= vs_d;
      pix_underflow <= uf_d;
    end
  end

  AST_UF_STICKY: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    pix_underflow |=> pix_underflow); // R10
  AST_UF_FLAG_SET: assert property (@(posedge clk_pix) disable iff (!rst_pix_n)
    (active && fifo_empty) |=> pix_underflow); // R10
endmodule

// File: tb/test_dtp_display_ctrl.sv
module test_dtp_display_ctrl;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HA * VA;
  localparam int FCYC = HT * VT;
  localparam int BASE = 24'h000100;
  localparam int BURST = 4;
  localparam logic [23:0] UF = 24'h00FF00;

  logic clk_bus = 1'b0, clk_pix = 1'b0;
  logic rst_bus_n = 1'b0, rst_pix_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic mem_req, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [23:0] mem_addr, mem_rdata = '0;
  logic [23:0] pix_rgb;
  logic pix_hsync, pix_vsync, pix_de, pix_underflow;

  always #10 clk_bus = ~clk_bus;
  always #17 clk_pix = ~clk_pix;

  dtp_display_ctrl i_dtp_display_ctrl (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .clk_pix(clk_pix),
    .rst_pix_n(rst_pix_n), .pix_rgb(pix_rgb), .pix_hsync(pix_hsync),
    .pix_vsync(pix_vsync), .pix_de(pix_de), .pix_underflow(pix_underflow)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [23:0] pat(int a);
    return 24'h800000 | 24'(a & 32'h7FFFFF);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // memory model
  bit stall = 1'b0;
  int ph = 0, baddr = 0, exp_addr = BASE, addr_err = 0, bursts = 0;
  always @(negedge clk_bus) begin
    if (ph == 0) begin
      mem_rvalid <= 1'b0;
      if (mem_req && !stall && !mem_ack) begin
        mem_ack <= 1'b1;
        baddr = int'(mem_addr);
        if (baddr != exp_addr) addr_err++;
        exp_addr = exp_addr + BURST;
        if (exp_addr == BASE + FRAME) exp_addr = BASE;
        bursts++;
        ph = 1;
      end else mem_ack <= 1'b0;
    end else if (ph <= BURST) begin
      mem_ack    <= 1'b0;
      mem_rvalid <= 1'b1;
      mem_rdata  <= pat(baddr + ph - 1);
      ph++;
    end else begin
      mem_rvalid <= 1'b0;
      ph = 0;
    end
  end

  // pixel monitor
  int cyc = 0, idx = 0, px_seen = 0, px_err = 0, blank_err = 0;
  int de_cur = 0, de_run = 0, de_rise = 0, de_tog = 0;
  int hs_tog = 0, hs_rise = 0, hs_run = 0, hs_per = 0;
  int vs_tog = 0, vs_rise = 0, vs_run = 0, vs_per = 0;
  int uf_seen = 0, uf_err = 0, first_de = -1, arm_cyc = 0;
  int last_got = 0, last_exp = 0;
  bit armed = 0, chk_data = 0, chk_uf = 0, de_mode_b = 0, hpol_b = 0, vpol_b = 0;
  bit de_prev = 0, hs_prev = 0, vs_prev = 0;
  logic [23:0] mask = 24'hFFFFFF;
  always @(negedge clk_pix) begin
    bit hs_a, vs_a;
    cyc++;
    if (pix_de) begin
      if (armed && first_de < 0) first_de = cyc;
      px_seen++;
      if (chk_data && pix_rgb !== (pat(BASE + idx) & mask)) begin
        px_err++; last_got = int'(pix_rgb); last_exp = int'(pat(BASE + idx) & mask);
      end
      if (chk_uf) begin uf_seen++; if (pix_rgb !== UF) uf_err++; end
      idx = (idx + 1) % FRAME;
      de_cur++;
    end else if (de_prev) begin
      de_run = de_cur; de_cur = 0;
    end
    if (pix_de && !de_prev) de_rise++;
    if (pix_de != de_prev) de_tog++;
    if (!pix_de && de_mode_b && pix_rgb !== '0) blank_err++;
    hs_a = (pix_hsync === hpol_b);
    if (hs_a != hs_prev) begin
      hs_tog++;
      if (hs_a) begin hs_per = cyc - hs_rise; hs_rise = cyc; end
      else hs_run = cyc - hs_rise;
    end
    vs_a = (pix_vsync === vpol_b);
    if (vs_a != vs_prev) begin
      vs_tog++;
      if (vs_a) begin vs_per = cyc - vs_rise; vs_rise = cyc; end
      else vs_run = cyc - vs_rise;
    end
    de_prev = pix_de; hs_prev = hs_a; vs_prev = vs_a;
  end

  task automatic pwait(int n);
    repeat (n) @(posedge clk_pix);
  endtask

  task automatic wr(logic [3:0] a, int d);
    @(negedge clk_bus);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = 24'(d);
    @(negedge clk_bus);
    cfg_wr = 1'b0;
  endtask

  task automatic test_reset;
    pwait(2);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "pix_de", int'(pix_de), 0);
    chk("R1", "pix_rgb", int'(pix_rgb), 0);
    chk("R1", "pix_underflow", int'(pix_underflow), 0);
    chk("R1", "syncs idle high", int'({pix_hsync, pix_vsync}), 3);
  endtask

  task automatic test_startup;
    wr(4'd1, HA); wr(4'd2, HF); wr(4'd3, HS); wr(4'd4, HB);
    wr(4'd5, VA); wr(4'd6, VF); wr(4'd7, VS); wr(4'd8, VB);
    wr(4'd9, BASE);
    de_mode_b = 1; chk_data = 1;
    wr(4'd0, 32'h03);  // R2 control: enable + data-enable mode
    arm_cyc = cyc; armed = 1;
    for (int i = 0; i < 4 * FCYC && first_de < 0; i++) pwait(1);
    chk_rng("R8", "first de latency", first_de - arm_cyc, (VF + VS + VB) * HT, (VF + VS + VB) * HT + 6);
  endtask

  task automatic test_de_frames;
    pwait(2);
    px_seen = 0; px_err = 0; blank_err = 0; de_rise = 0; hs_tog = 0; vs_tog = 0; addr_err = 0;
    pwait(3 * FCYC);
    chk("R6", "pixel data errors", px_err, 0);
    if (px_err != 0) $display("  last pixel actual %h expected %h", last_got, last_exp);
    chk("R5", "active pixels in 3 frames", px_seen, 3 * FRAME);
    chk("R6", "non-black blanking", blank_err, 0);
    chk("R5", "de run per line", de_run, HA);
    chk("R5", "lines per 3 frames", de_rise, 3 * VA);
    chk("R5", "sync toggles in de mode", hs_tog + vs_tog, 0);
    chk("R7", "burst address errors", addr_err, 0);
    chk_rng("R7", "bursts seen", bursts, 3 * FRAME / BURST, 100000);
    chk("R8", "no underflow in steady state", int'(pix_underflow), 0);
  endtask

  task automatic test_mode18;
    chk_data = 0;
    wr(4'd0, 32'h13);
    pwait(FCYC);
    mask = 24'hFCFCFC; px_err = 0; px_seen = 0; chk_data = 1;
    pwait(2 * FCYC);
    chk("R9", "18-bit pixel errors", px_err, 0);
    chk("R9", "18-bit pixels seen", px_seen, 2 * FRAME);
  endtask

  task automatic test_sync_mode;
    chk_data = 0; de_mode_b = 0; mask = 24'hFFFFFF;
    wr(4'd0, 32'h01);
    pwait(FCYC);
    de_tog = 0;
    pwait(2 * FCYC);
    chk("R5", "de toggles in sync mode", de_tog, 0);
    chk("R3", "hsync width", hs_run, HS);
    chk("R3", "hsync period", hs_per, HT);
    chk("R3", "vsync width", vs_run, VS * HT);
    chk("R3", "vsync period", vs_per, FCYC);
  endtask

  task automatic test_polarity;
    wr(4'd0, 32'h0D);
    hpol_b = 1; vpol_b = 1;
    pwait(2 * FCYC);
    chk("R4", "active-high hsync width", hs_run, HS);
    chk("R4", "active-high vsync width", vs_run, VS * HT);
  endtask

  task automatic test_underflow;
    stall = 1; de_mode_b = 1; hpol_b = 0; vpol_b = 0;
    wr(4'd0, 32'h03);
    pwait(3 * FCYC);
    uf_seen = 0; uf_err = 0; chk_uf = 1;
    pwait(FCYC);
    chk_uf = 0;
    chk("R10", "starved pixels seen", uf_seen, FRAME);
    chk("R10", "starved pixel colour errors", uf_err, 0);
    chk("R10", "underflow flag set", int'(pix_underflow), 1);
    stall = 0;
    pwait(2 * FCYC);
    chk("R10", "underflow flag sticky", int'(pix_underflow), 1);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (5) @(negedge clk_bus);
    test_reset;
    @(negedge clk_bus); rst_bus_n = 1'b1;
    @(negedge clk_pix); rst_pix_n = 1'b1;
    test_reset;
    test_startup;
    test_de_frames;
    test_mode18;
    test_sync_mode;
    test_polarity;
    test_underflow;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_bus);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      summary;
      $finish;
    end
  end
endmodule